// File: doc/BRIEF.md
# Serial Converter Port Model with Mode Select and Cascade Path

This block is a synthesizable model of the digital serial port of an 18-bit sampling converter. It exists to exercise host controllers. No analog core is modelled: the sample value comes in on a parallel bus, and the block puts it on a serial line the way the real port would. A system clock samples the three host lines, which are the convert strobe, the serial clock and the serial data input, and it finds their edges.

A rising edge of the convert strobe starts a conversion and fixes one of two operating modes. If the serial data input is low at that edge, the block enters cascade mode. In cascade mode the serial input becomes a data input that comes out on the serial output exactly 18 serial clocks later, so several instances can be chained onto one wire. If the serial input is high at that edge, the block enters select mode. In select mode the output is driven only while either the serial input or the strobe is held low. A leading start marker can also be added to the word.

After a fixed number of system clocks the block captures the sample bus. It then shifts the word out MSB first and moves one bit on each serial clock falling edge. The output is a data line plus an output-enable line rather than a true tri-state.

Top module: `adc_serial_port`

## Requirements
- R1: At an accepted rising edge of `cnv`, `sdi` high selects select mode and `sdi` low selects cascade mode. Reset leaves the block in select mode.
- R2: A conversion lasts `CONV_CYCLES` clock cycles from the edge that detects the `cnv` rise. The word is taken from `sample` on the final cycle of that count. A `cnv` rise that arrives while a conversion is running is ignored and does not change the mode.
- R3: The word is sent MSB first as the raw 18-bit two's complement value. `sdo` moves to the next bit only when a falling edge of `sck` is detected.
- R4: Falling edges of `sck` that arrive during a conversion do not shift the word.
- R5: In cascade mode, the level of `sdi` at each `sck` falling edge reaches `sdo` after 18 further falling edges. The bits behind the word are therefore the upstream bits, in order.
- R6: In cascade mode, `sdo_oe` is 1 at all times.
- R7: In select mode, `sdo_oe` is 0 whenever `sdi` and `cnv` are both high.
- R8: In select mode, if `sdi` or `cnv` is low when the conversion completes, a start marker is used. `sdo` is 1 during the conversion and becomes 0 at completion. The first `sck` falling edge then brings out the MSB.
- R9: In select mode, the falling edge after the last data bit sets `sdo_oe` to 0. That is the 18th falling edge without a marker and the 19th with one. `sdo_oe` stays 0 until the next conversion starts, even with the enable line low and more `sck` edges.
- R10: Right after reset, `sdo_oe` is 0 even when `sdi` or `cnv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all host lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Convert strobe from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Mode select at the strobe edge, then cascade data input |
| sample | input | DATA_W | Conversion value, captured when the conversion completes |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo` (0 means high impedance) |

## Verification
One table-driven loop runs the word path in three setups: select mode with a start marker, select mode without one, and cascade mode. The values include alternating bits, all ones, the most negative code and a lone LSB. These values expose a dropped bit, an off-by-one in the shift count, or an LSB-first ordering. A cascade test sends a known 18-bit upstream pattern and reads it back behind the word, which shows whether the delay is exactly 18 edges. Directed tests cover serial clocks sent mid-conversion, a second strobe rise with `sdi` low mid-conversion (ignored, so the mode is kept), a `sample` change before completion, the exact completion cycle seen through the marker, and the output staying disabled after the word drains.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  typedef enum logic {
    MODE_SELECT = 1'b0,
    MODE_CHAIN  = 1'b1
  } port_mode_e;

  // Mode chosen by the level of the serial input at the strobe edge
  function automatic port_mode_e mode_of(input logic sdi_lvl);
    return sdi_lvl ? MODE_SELECT : MODE_CHAIN;
  endfunction

  // Number of serial falling edges needed to drain a word
  function automatic int unsigned drain_len(input int unsigned width, input logic marker);
    return width + (marker ? 1 : 0);
  endfunction

endpackage

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse = lvl & ~prev_q;
    end else begin : g_fall
      assign pulse = ~lvl & prev_q;
    end
  endgenerate

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R3

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CONV_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic converting,
  output logic done
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign converting = (cnt_q != '0);
  assign done       = (cnt_q == CW'(1));

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R2
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !converting); // R2

endmodule

// File: rtl/out_shifter.sv
module out_shifter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         load,
  input  logic         lead_req,
  input  logic [W-1:0] sample,
  input  logic         shift_en,
  input  logic         chain,
  input  logic         ser_in,
  output logic         data_bit,
  output logic         drained
);
  localparam int BW = $clog2(W + 2);
  localparam logic [BW-1:0] LEN_PLAIN = BW'(adc_port_pkg::drain_len(W, 1'b0));
  localparam logic [BW-1:0] LEN_LEAD  = BW'(adc_port_pkg::drain_len(W, 1'b1));

  logic [W-1:0]  sr_q;
  logic          lead_q;
  logic [BW-1:0] left_q;
  logic          drained_q;

  function automatic logic [W-1:0] push(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q      <= '0;
      lead_q    <= 1'b0;
      left_q    <= '0;
      drained_q <= 1'b1;
    end else begin
      if (start) drained_q <= 1'b0;
      if (load) begin
        sr_q   <= sample;
        lead_q <= lead_req;
        left_q <= lead_req ? LEN_LEAD : LEN_PLAIN;
      end else if (shift_en) begin
        if (chain) begin
          sr_q <= push(sr_q, ser_in);
        end else if (left_q != '0) begin
          if (lead_q) lead_q <= 1'b0;
          else        sr_q   <= push(sr_q, 1'b0);
          left_q <= left_q - 1'b1;
          if (left_q == BW'(1)) drained_q <= 1'b1;
        end
      end
    end
  end

  assign data_bit = lead_q ? 1'b0 : sr_q[W-1];
  assign drained  = drained_q;

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (data_bit == ($past(lead_req) ? 1'b0 : $past(sample[W-1])))); // R2
  AST_DRAIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (drained && !start) |=> drained); // R9

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W      = 18,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo,
  output logic              sdo_oe
);
  import adc_port_pkg::*;

  // Named internal events
  logic cnv_rise;
  logic sck_fall;
  logic converting;
  logic conv_done;
  logic accept;
  logic shift_en;
  logic en_line;
  logic lead_req;
  logic data_bit;
  logic drained;
  logic is_chain;

  port_mode_e mode_q;

  edge_detect #(.RISE(1'b1)) u_cnv_edge (
    .clk(clk), .rst_n(rst_n), .lvl(cnv), .pulse(cnv_rise)
  );

  edge_detect #(.RISE(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sck), .pulse(sck_fall)
  );

  assign accept = cnv_rise && !converting;

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .converting(converting), .done(conv_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= MODE_SELECT;
    else if (accept) mode_q <= mode_of(sdi);
  end

  assign is_chain = (mode_q == MODE_CHAIN);
  assign en_line  = !sdi || !cnv;
  assign lead_req = !is_chain && en_line;
  assign shift_en = sck_fall && !converting;

  out_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(accept), .load(conv_done),
    .lead_req(lead_req), .sample(sample), .shift_en(shift_en),
    .chain(is_chain), .ser_in(sdi), .data_bit(data_bit), .drained(drained)
  );

  assign sdo    = (!is_chain && converting) ? 1'b1 : data_bit;
  assign sdo_oe = is_chain || (en_line && !drained);

  AST_MODE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mode_q == ($past(sdi) ? MODE_SELECT : MODE_CHAIN))); // R1
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !conv_done) |=> $stable(data_bit)); // R3
  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (converting && sck_fall && !conv_done) |=> $stable(data_bit)); // R4
  AST_SELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_chain && sdi && cnv) |-> !sdo_oe); // R7
  AST_MARKER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && lead_req) |=> (sdo == 1'b0)); // R8

endmodule

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam int W = 18;
  localparam int C = 12;

  typedef struct packed {
    logic         chain;
    logic         marker;
    logic [W-1:0] val;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 18'h2AAAA},
    '{1'b0, 1'b1, 18'h1FFFF},
    '{1'b1, 1'b0, 18'h20000},
    '{1'b0, 1'b1, 18'h3FFFF},
    '{1'b1, 1'b0, 18'h00001},
    '{1'b0, 1'b0, 18'h15A5C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0;
  logic sck = 1'b0;
  logic sdi = 1'b1;
  logic [W-1:0] sample = '0;
  logic sdo, sdo_oe;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_serial_port #(.DATA_W(W), .CONV_CYCLES(C)) u0 (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
    .sample(sample), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic fall();
    sck = 1'b1; tick();
    sck = 1'b0; tick();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_word(output logic [W-1:0] got);
    got = '0;
    for (int i = 0; i < W; i++) begin
      got = {got[W-2:0], sdo};
      fall();
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [W-1:0] got;
    sample = v.val;
    sdi = !v.chain; cnv = 1'b1; tick();
    sdi = v.chain ? 1'b0 : (v.marker ? 1'b0 : 1'b1);
    repeat (C) tick();
    if (!v.chain && !v.marker) begin
      chk("R1 R7 deselected", sdo_oe, 0);
      cnv = 1'b0; tick();
      chk("R7 enabled by cnv low", sdo_oe, 1);
    end
    if (v.marker) begin
      chk("R8 marker low", sdo, 0);
      fall();
    end
    read_word(got);
    chk("R3 word", got, v.val);
    if (!v.chain) chk("R9 off after last bit", sdo_oe, 0);
    else          chk("R6 chain drives", sdo_oe, 1);
    cnv = 1'b0; sdi = 1'b1; tick(); tick();
  endtask

  initial begin
    logic [W-1:0] got;
    logic [W-1:0] pat;
    repeat (3) tick();
    rst_n = 1'b1; tick();
    chk("R10 oe after reset", sdo_oe, 0);
    sdi = 1'b0; tick();
    chk("R10 oe with enable low", sdo_oe, 0);
    sdi = 1'b1; tick();

    foreach (VECS[i]) run_vec(VECS[i]);

    // R9: extra edges after drain keep output off
    fall();
    chk("R9 stays off", sdo_oe, 0);

    // R4: serial clocks during conversion are ignored
    sample = 18'h3C0F3; sdi = 1'b1; cnv = 1'b1; tick();
    repeat (3) fall();
    repeat (C - 6) tick();
    cnv = 1'b0; tick();
    read_word(got);
    chk("R4 word after mid-conversion clocks", got, 18'h3C0F3);
    sdi = 1'b1; tick();

    // R2: exact completion cycle seen through the marker
    sample = 18'h0F0F0; sdi = 1'b1; cnv = 1'b1; tick();
    sdi = 1'b0;
    repeat (C - 1) tick();
    chk("R8 busy high in conversion", sdo, 1);
    chk("R2 oe during conversion", sdo_oe, 1);
    tick();
    chk("R2 marker at completion", sdo, 0);
    fall();
    read_word(got);
    chk("R2 marker word", got, 18'h0F0F0);
    cnv = 1'b0; sdi = 1'b1; tick(); tick();

    // R2: second rise ignored, sample taken at completion
    sample = 18'h11111; sdi = 1'b1; cnv = 1'b1; tick();
    repeat (3) tick();
    sample = 18'h2E6D9;
    cnv = 1'b0; tick();
    sdi = 1'b0; cnv = 1'b1; tick();
    sdi = 1'b1;
    repeat (C - 5) tick();
    chk("R1 R2 mode kept", sdo_oe, 0);
    cnv = 1'b0; tick();
    read_word(got);
    chk("R2 late sample", got, 18'h2E6D9);
    sdi = 1'b1; tick();

    // R5: cascade delay of exactly 18 edges
    pat = 18'h2D3C6;
    sample = 18'h155AA; sdi = 1'b0; cnv = 1'b1; tick();
    repeat (C) tick();
    got = '0;
    for (int i = 0; i < W; i++) begin
      got = {got[W-2:0], sdo};
      sdi = pat[W-1-i];
      fall();
    end
    chk("R5 own word first", got, 18'h155AA);
    sdi = 1'b0;
    read_word(got);
    chk("R5 upstream bits", got, pat);
    chk("R6 chain oe", sdo_oe, 1);
    cnv = 1'b0; sdi = 1'b1; tick();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule